// File: doc/BRIEF.md
# Control Register File with Banked Stack Pointer

This block is a small processor control-register file. A 4-bit index selects the register. One port reads it and one port writes it. Reads are combinational. A write takes effect on the rising clock edge when its strobe is high. The file holds:

- a status word built from a status byte, a backup status byte and a separate condition flag;
- a second-level backup status byte;
- two backup program counters;
- two plain spare registers;
- two stack-pointer banks.

The block also owns the live stack pointer that the general register file uses. The live value is on `sp_o`, and a separate strobe writes it directly.

Bit 7 of the status byte is the stack mode. Mode 0 means the live stack pointer is the interrupt stack pointer. Mode 1 means it is the user stack pointer. The stack-pointer indices give access either to the live value or to the banked copy, depending on the mode. When a status write changes the mode, the block swaps stacks in the same clock edge. The outgoing live value is saved into its bank, and the live register is loaded from the other bank.

Top module: `cr_file`

## Requirements
- R1: After reset every index reads 0, `sp_o` is 0 and `stack_mode_o` is 0.
- R2: Reading index 0 returns bits 15:14 and 8 of the status word from the backup status byte (its bits 7, 6 and 0). It returns bits 7:6 from the status byte. Bit 0 is the condition flag. All other bits read 0.
- R3: Writing index 0 sets the backup status byte from data bits 15:8, the status byte from bits 7:0, and the condition flag from bit 0. `stack_mode_o` then equals data bit 7.
- R4: Index 1 reads the condition flag in bit 0 with zeros above it. A write to index 1 changes only the flag, taking it from data bit 0.
- R5: A status write that changes the mode from 0 to 1 saves the live SP into the interrupt bank and loads the live SP from the user bank.
- R6: A status write that changes the mode from 1 to 0 saves the live SP into the user bank and loads the live SP from the interrupt bank.
- R7: Index 2 (interrupt SP) reads and writes the live SP in mode 0 and the interrupt bank in mode 1. Index 3 (user SP) reads and writes the live SP in mode 1 and the user bank in mode 0.
- R8: Index 8 takes data bits 7:0 as the second-level backup status byte. It reads back as that byte ANDed with 0xC1, zero-extended.
- R9: Index 6 (backup PC) and index 7 (second-level backup PC) read back the written value with bit 0 forced to 0.
- R10: Indices 4 and 5 are plain 32-bit registers that read back exactly what was written.
- R11: Indices 9 to 15 read 0. Writes to them change no register, `sp_o` or `stack_mode_o`.
- R12: When a mode-changing status write and a direct SP write (`sp_we_i`) occur in the same cycle, the swap wins. The live SP takes the restored bank value.
- R13: A direct SP write loads `sp_o` on the next edge, unless the same cycle carries a swap. It is also overridden when the control port writes the index that currently maps to the live SP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 4 | Read index |
| rd_data_o | output | 32 | Combinational read data |
| wr_en_i | input | 1 | Control-port write strobe |
| wr_idx_i | input | 4 | Control-port write index |
| wr_data_i | input | 32 | Control-port write data |
| sp_we_i | input | 1 | Direct write strobe for the live SP |
| sp_wdata_i | input | 32 | Direct write data for the live SP |
| sp_o | output | 32 | Live stack pointer |
| stack_mode_o | output | 1 | Current stack mode (status bit 7) |

## Verification
The assertions assume that the control port carries at most one index per cycle. They also assume that only a write to index 0 can change the mode, so a swap never coincides with a control write to a stack-pointer index. The bench drives every input on the falling edge and clears the strobes just after the rising edge, so each write lands on exactly one edge. The stimulus includes mode-changing status writes with and without a direct SP write in the same cycle, so that both swap directions meet the priority rule.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int unsigned IDX_STAT       = 0;
  localparam int unsigned IDX_COND       = 1;
  localparam int unsigned IDX_ISP        = 2;
  localparam int unsigned IDX_USP        = 3;
  localparam int unsigned IDX_SPARE_BASE = 4;
  localparam int unsigned SPARE_CNT      = 2;
  localparam int unsigned IDX_BPC        = 6;
  localparam int unsigned IDX_BBPC       = 7;
  localparam int unsigned IDX_BBSTAT     = 8;
  localparam int unsigned IDX_LAST       = 8;
  localparam int unsigned MODE_BIT       = 7;

  // Only the bits that a read can observe are kept.
  typedef struct packed {
    logic b7;
    logic b6;
    logic b0;
  } byte_c1_t;

  typedef struct packed {
    logic mode;
    logic b6;
  } stat_hi_t;
endpackage

// File: rtl/cr_status.sv
module cr_status
  import cr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_stat_i,
  input  logic        wr_cond_i,
  input  logic        wr_bbstat_i,
  input  byte_c1_t    bstat_d_i,
  input  stat_hi_t    stat_d_i,
  input  logic        cond_d_i,
  input  byte_c1_t    bbstat_d_i,
  output logic [15:0] stat_rd_o,
  output logic [7:0]  bbstat_rd_o,
  output logic        cond_o,
  output logic        mode_o,
  output logic        swap_o
);
  byte_c1_t bstat_q, bbstat_q;
  stat_hi_t stat_q;
  logic     cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bstat_q  <= '0;
      bbstat_q <= '0;
      stat_q   <= '0;
      cond_q   <= 1'b0;
    end else begin
      if (wr_stat_i) begin
        bstat_q <= bstat_d_i;
        stat_q  <= stat_d_i;
      end
      if (wr_stat_i || wr_cond_i) cond_q <= cond_d_i;
      if (wr_bbstat_i) bbstat_q <= bbstat_d_i;
    end
  end

  assign stat_rd_o   = {bstat_q.b7, bstat_q.b6, 5'b0, bstat_q.b0,
                        stat_q.mode, stat_q.b6, 5'b0, cond_q};
  assign bbstat_rd_o = {bbstat_q.b7, bbstat_q.b6, 5'b0, bbstat_q.b0};
  assign cond_o      = cond_q;
  assign mode_o      = stat_q.mode;
  assign swap_o      = wr_stat_i && (stat_d_i.mode != stat_q.mode);

  assert_cond_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i || wr_cond_i) |=> cond_o == $past(cond_d_i));
  assert_mode_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i |=> mode_o == $past(stat_d_i.mode));
  assert_cond_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stat_i && !wr_cond_i) |=> $stable(cond_o));
  assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat_i |=> $stable(mode_o));
endmodule

// File: rtl/cr_sp_bank.sv
module cr_sp_bank #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          swap_i,
  input  logic          wr_isp_i,
  input  logic          wr_usp_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ext_we_i,
  input  logic [DW-1:0] ext_data_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] isp_rd_o,
  output logic [DW-1:0] usp_rd_o
);
  logic [DW-1:0] sp_q, isp_q, usp_q;
  logic [DW-1:0] sp_d, isp_d, usp_d;

  always_comb begin
    sp_d  = sp_q;
    isp_d = isp_q;
    usp_d = usp_q;
    if (swap_i) begin
      if (!mode_i) begin
        isp_d = sp_q;
        sp_d  = usp_q;
      end else begin
        usp_d = sp_q;
        sp_d  = isp_q;
      end
    end else begin
      if (ext_we_i) sp_d = ext_data_i;
      // Control-port writes come later and override the direct write.
      if (wr_isp_i) begin
        if (mode_i) isp_d = wr_data_i;
        else        sp_d  = wr_data_i;
      end
      if (wr_usp_i) begin
        if (mode_i) sp_d  = wr_data_i;
        else        usp_d = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      sp_q  <= sp_d;
      isp_q <= isp_d;
      usp_q <= usp_d;
    end
  end

  assign sp_o     = sp_q;
  assign isp_rd_o = mode_i ? isp_q : sp_q;
  assign usp_rd_o = mode_i ? sp_q  : usp_q;

  assert_swap_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && !mode_i) |=> (isp_q == $past(sp_q)) && (sp_q == $past(usp_q)));
  assert_swap_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && mode_i) |=> (usp_q == $past(sp_q)) && (sp_q == $past(isp_q)));
  assert_swap_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && ext_we_i) |=> sp_q == $past(mode_i ? isp_q : usp_q));
  assert_banks_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && !wr_isp_i && !wr_usp_i) |=> $stable(isp_q) && $stable(usp_q));
  assert_ext_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_we_i && !swap_i && !wr_isp_i && !wr_usp_i) |=> sp_o == $past(ext_data_i));
  assert_one_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({swap_i, wr_isp_i, wr_usp_i}) <= 1);
endmodule

// File: rtl/cr_plain_regs.sv
module cr_plain_regs
  import cr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned IW     = 4,
  parameter int unsigned NSPARE = SPARE_CNT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IW-1:0]              wr_idx_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic [DW-1:0]              bpc_rd_o,
  output logic [DW-1:0]              bbpc_rd_o,
  output logic [NSPARE-1:0][DW-1:0]  spare_o
);
  // Bit 0 of the PCs is never visible, so it is not stored.
  logic [DW-1:1] bpc_q, bbpc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpc_q  <= '0;
      bbpc_q <= '0;
    end else if (wr_en_i) begin
      if (wr_idx_i == IW'(IDX_BPC))  bpc_q  <= wr_data_i[DW-1:1];
      if (wr_idx_i == IW'(IDX_BBPC)) bbpc_q <= wr_data_i[DW-1:1];
    end
  end

  assign bpc_rd_o  = {bpc_q, 1'b0};
  assign bbpc_rd_o = {bbpc_q, 1'b0};

  for (genvar g = 0; g < NSPARE; g++) begin : g_spare
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && wr_idx_i == IW'(IDX_SPARE_BASE + g)) q <= wr_data_i;
    end
    assign spare_o[g] = q;
  end
endmodule

// File: rtl/cr_read_mux.sv
module cr_read_mux
  import cr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned IW     = 4,
  parameter int unsigned NSPARE = SPARE_CNT
) (
  input  logic [IW-1:0]             rd_idx_i,
  input  logic [15:0]               stat_rd_i,
  input  logic                      cond_i,
  input  logic [DW-1:0]             isp_rd_i,
  input  logic [DW-1:0]             usp_rd_i,
  input  logic [NSPARE-1:0][DW-1:0] spare_i,
  input  logic [DW-1:0]             bpc_rd_i,
  input  logic [DW-1:0]             bbpc_rd_i,
  input  logic [7:0]                bbstat_rd_i,
  output logic [DW-1:0]             rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_idx_i == IW'(IDX_STAT))   rd_data_o = DW'(stat_rd_i);
    if (rd_idx_i == IW'(IDX_COND))   rd_data_o = DW'(cond_i);
    if (rd_idx_i == IW'(IDX_ISP))    rd_data_o = isp_rd_i;
    if (rd_idx_i == IW'(IDX_USP))    rd_data_o = usp_rd_i;
    if (rd_idx_i == IW'(IDX_BPC))    rd_data_o = bpc_rd_i;
    if (rd_idx_i == IW'(IDX_BBPC))   rd_data_o = bbpc_rd_i;
    if (rd_idx_i == IW'(IDX_BBSTAT)) rd_data_o = DW'(bbstat_rd_i);
    for (int k = 0; k < int'(NSPARE); k++) begin
      if (rd_idx_i == IW'(IDX_SPARE_BASE + k)) rd_data_o = spare_i[k];
    end
  end
endmodule

// File: rtl/cr_file.sv
module cr_file
  import cr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sp_we_i,
  input  logic [DW-1:0] sp_wdata_i,
  output logic [DW-1:0] sp_o,
  output logic          stack_mode_o
);
  localparam int unsigned NSPARE = SPARE_CNT;

  logic wr_stat, wr_cond, wr_isp, wr_usp, wr_bbstat;
  logic [15:0] stat_rd;
  logic [7:0]  bbstat_rd;
  logic        cond, mode, swap;
  logic [DW-1:0] isp_rd, usp_rd, bpc_rd, bbpc_rd;
  logic [NSPARE-1:0][DW-1:0] spare;

  assign wr_stat   = wr_en_i && (wr_idx_i == IW'(IDX_STAT));
  assign wr_cond   = wr_en_i && (wr_idx_i == IW'(IDX_COND));
  assign wr_isp    = wr_en_i && (wr_idx_i == IW'(IDX_ISP));
  assign wr_usp    = wr_en_i && (wr_idx_i == IW'(IDX_USP));
  assign wr_bbstat = wr_en_i && (wr_idx_i == IW'(IDX_BBSTAT));

  cr_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_stat_i   (wr_stat),
    .wr_cond_i   (wr_cond),
    .wr_bbstat_i (wr_bbstat),
    .bstat_d_i   ('{b7: wr_data_i[15], b6: wr_data_i[14], b0: wr_data_i[8]}),
    .stat_d_i    ('{mode: wr_data_i[MODE_BIT], b6: wr_data_i[6]}),
    .cond_d_i    (wr_data_i[0]),
    .bbstat_d_i  ('{b7: wr_data_i[7], b6: wr_data_i[6], b0: wr_data_i[0]}),
    .stat_rd_o   (stat_rd),
    .bbstat_rd_o (bbstat_rd),
    .cond_o      (cond),
    .mode_o      (mode),
    .swap_o      (swap)
  );

  cr_sp_bank #(.DW(DW)) u_sp_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .swap_i     (swap),
    .wr_isp_i   (wr_isp),
    .wr_usp_i   (wr_usp),
    .wr_data_i  (wr_data_i),
    .ext_we_i   (sp_we_i),
    .ext_data_i (sp_wdata_i),
    .sp_o       (sp_o),
    .isp_rd_o   (isp_rd),
    .usp_rd_o   (usp_rd)
  );

  cr_plain_regs #(.DW(DW), .IW(IW), .NSPARE(NSPARE)) u_plain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .bpc_rd_o  (bpc_rd),
    .bbpc_rd_o (bbpc_rd),
    .spare_o   (spare)
  );

  cr_read_mux #(.DW(DW), .IW(IW), .NSPARE(NSPARE)) u_rd_mux (
    .rd_idx_i    (rd_idx_i),
    .stat_rd_i   (stat_rd),
    .cond_i      (cond),
    .isp_rd_i    (isp_rd),
    .usp_rd_i    (usp_rd),
    .spare_i     (spare),
    .bpc_rd_i    (bpc_rd),
    .bbpc_rd_i   (bbpc_rd),
    .bbstat_rd_i (bbstat_rd),
    .rd_data_o   (rd_data_o)
  );

  assign stack_mode_o = mode;

  assert_pc_even_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == IW'(IDX_BPC) || rd_idx_i == IW'(IDX_BBPC)) |-> !rd_data_o[0]);
  assert_undef_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i > IW'(IDX_LAST)) |-> rd_data_o == '0);
  assert_undef_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i > IW'(IDX_LAST) && !sp_we_i) |=> $stable(sp_o) && $stable(stack_mode_o));
  assert_status_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == IW'(IDX_STAT)) |-> rd_data_o[DW-1:16] == '0);
endmodule

// File: tb/cr_file_bench.sv
`timescale 1ns/1ps
module cr_file_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        sp_we = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic [31:0] sp_out;
  logic        mode_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0]  m_stat, m_bstat, m_bbstat;
  logic        m_cond;
  logic [31:0] m_sp, m_isp, m_usp, m_bpc, m_bbpc, m_sp4, m_sp5;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  cr_file u_cr_file (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rd_idx_i     (rd_idx),
    .rd_data_o    (rd_data),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_data_i    (wr_data),
    .sp_we_i      (sp_we),
    .sp_wdata_i   (sp_wdata),
    .sp_o         (sp_out),
    .stack_mode_o (mode_out)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] exp_rd(int idx);
    case (idx)
      0: return {16'h0, m_bstat & 8'hC1, (m_stat & 8'hC0) | {7'b0, m_cond}};
      1: return {31'b0, m_cond};
      2: return m_stat[7] ? m_isp : m_sp;
      3: return m_stat[7] ? m_sp : m_usp;
      4: return m_sp4;
      5: return m_sp5;
      6: return m_bpc & ~32'h1;
      7: return m_bbpc & ~32'h1;
      8: return {24'h0, m_bbstat & 8'hC1};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R2";
      1: return "R4";
      2, 3: return "R7";
      4, 5: return "R10";
      6, 7: return "R9";
      8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, int idx, logic [31:0] exp);
    rd_idx = 4'(idx);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic model_update(logic we, int idx, logic [31:0] d, logic spwe, logic [31:0] spd);
    logic old_mode, flip, live_cr;
    logic [31:0] sp0, isp0, usp0;
    old_mode = m_stat[7];
    flip     = we && idx == 0 && d[7] != old_mode;
    live_cr  = we && ((idx == 2 && !old_mode) || (idx == 3 && old_mode));
    sp0 = m_sp; isp0 = m_isp; usp0 = m_usp;
    if (we) begin
      case (idx)
        0: begin m_bstat = d[15:8]; m_stat = d[7:0]; m_cond = d[0]; end
        1: m_cond = d[0];
        2: if (old_mode) m_isp = d; else m_sp = d;
        3: if (old_mode) m_sp = d; else m_usp = d;
        4: m_sp4 = d;
        5: m_sp5 = d;
        6: m_bpc = d;
        7: m_bbpc = d;
        8: m_bbstat = d[7:0];
        default: ;
      endcase
    end
    if (flip) begin
      if (!old_mode) begin m_isp = sp0; m_sp = usp0; end
      else begin m_usp = sp0; m_sp = isp0; end
    end else if (spwe && !live_cr) begin
      m_sp = spd;
    end
  endtask

  task automatic apply(logic we, int idx, logic [31:0] d, logic spwe, logic [31:0] spd);
    @(negedge clk);
    wr_en = we; wr_idx = 4'(idx); wr_data = d; sp_we = spwe; sp_wdata = spd;
    model_update(we, idx, d, spwe, spd);
    @(posedge clk);
    #1;
    wr_en = 1'b0; sp_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all R): actual 200000 cycles expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    m_stat = '0; m_bstat = '0; m_bbstat = '0; m_cond = 1'b0;
    m_sp = '0; m_isp = '0; m_usp = '0; m_bpc = '0; m_bbpc = '0; m_sp4 = '0; m_sp5 = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) rd_chk("R1", i, 32'h0);
    chk("R1", sp_out, 32'h0);
    chk("R1", {31'b0, mode_out}, 32'h0);

    // R13 direct SP write
    apply(1'b0, 0, 32'h0, 1'b1, 32'h0000_1111);
    chk("R13", sp_out, 32'h0000_1111);
    // R7 mode 0: user index hits bank, interrupt index is live
    apply(1'b1, 3, 32'h0000_2222, 1'b0, 32'h0);
    rd_chk("R7", 3, 32'h0000_2222);
    rd_chk("R7", 2, 32'h0000_1111);
    // R13 control write to live-mapped index beats direct write
    apply(1'b1, 2, 32'h0000_1111, 1'b1, 32'h0000_7777);
    chk("R13", sp_out, 32'h0000_1111);
    // R5 swap 0->1, status write R3
    apply(1'b1, 0, 32'h0000_C1FF, 1'b0, 32'h0);
    chk("R5", sp_out, 32'h0000_2222);
    rd_chk("R5", 2, 32'h0000_1111);
    rd_chk("R7", 3, 32'h0000_2222);
    rd_chk("R3", 0, 32'h0000_C1C1);
    chk("R3", {31'b0, mode_out}, 32'h1);
    // R6 swap 1->0 with same-cycle direct write, R12
    apply(1'b1, 0, 32'h0000_0000, 1'b1, 32'h0000_9999);
    chk("R12", sp_out, 32'h0000_1111);
    rd_chk("R6", 3, 32'h0000_2222);
    chk("R6", {31'b0, mode_out}, 32'h0);
    // R4 condition index
    apply(1'b1, 1, 32'hFFFF_FFFE, 1'b0, 32'h0);
    rd_chk("R4", 1, 32'h0);
    apply(1'b1, 1, 32'h0000_0003, 1'b0, 32'h0);
    rd_chk("R4", 1, 32'h1);
    rd_chk("R2", 0, 32'h0000_0001);
    // R9, R8, R10, R11
    apply(1'b1, 6, 32'hFFFF_FFFF, 1'b0, 32'h0);
    rd_chk("R9", 6, 32'hFFFF_FFFE);
    apply(1'b1, 8, 32'hFFFF_FFFF, 1'b0, 32'h0);
    rd_chk("R8", 8, 32'h0000_00C1);
    apply(1'b1, 4, 32'hA5A5_5A5A, 1'b0, 32'h0);
    rd_chk("R10", 4, 32'hA5A5_5A5A);
    apply(1'b1, 12, 32'hDEAD_BEEF, 1'b0, 32'h0);
    rd_chk("R11", 12, 32'h0);
    chk("R11", sp_out, 32'h0000_1111);
    for (int i = 0; i < 9; i++) rd_chk("R11", i, exp_rd(i));

    // Sweep: every index written with pseudo-random data, full read-back each time
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] d, spd;
        logic spwe;
        string sp_tag;
        d    = rnd();
        spd  = rnd();
        spwe = d[20];
        sp_tag = (i == 0 && d[7] != m_stat[7]) ? (spwe ? "R12" : (m_stat[7] ? "R6" : "R5")) : "R13";
        apply(1'b1, i, d, spwe, spd);
        chk(sp_tag, sp_out, m_sp);
        chk("R3", {31'b0, mode_out}, {31'b0, m_stat[7]});
        for (int k = 0; k < 16; k++) rd_chk(tag_of(k), k, exp_rd(k));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule